// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Back Cache

This block is a single-level data cache that sits between a processor load/store port and a word-wide memory. It holds 256 sets of four lines, and each line carries one 32-bit word. A request is split into a tag, a set index and a byte offset. The four lines of the selected set are compared at the same time. A hit returns the word in the same cycle through a selector that is driven by the matching way, so the data arrives after the hit decision.

On a miss the block holds the processor with a stall and picks a victim line in the set. It writes that line back to memory only if the line was modified. It then reads the requested word, installs it as a clean line, and replays the original access. A replayed write merges into the fresh line and marks it modified. The processor must keep its request steady while the stall is high.

The controller has four states. ST_LOOKUP compares tags and serves hits. ST_EVICT writes back a dirty victim. ST_FETCH reads the missing word. ST_INSTALL writes the fetched line. The transitions are:
- ST_LOOKUP to ST_EVICT on a miss whose victim is dirty.
- ST_LOOKUP to ST_FETCH on a miss whose victim is clean or invalid.
- ST_EVICT to ST_FETCH on memory acknowledge.
- ST_FETCH to ST_INSTALL on memory acknowledge.
- ST_INSTALL to ST_LOOKUP always.

Top module: `sa4_cache`

## Requirements
- R1: Address bits [31:10] form the tag and bits [9:2] select the set. Bits [1:0] are ignored. Every memory address the block issues is word-aligned, `{tag, set, 2'b00}`.
- R2: A request whose tag is held by a valid way of its set completes in the cycle it is presented. It has no stall and no memory request, and read data comes from the matching way.
- R3: At most one way of a set ever matches a given tag. A write to a line already present never allocates a second copy.
- R4: A request that misses raises the stall until it completes. A read miss fetches the word at its aligned address and returns the fetched value.
- R5: A write hit updates only the cached word and marks the line modified. It issues no memory write.
- R6: On a miss, the lowest-numbered invalid way of the set is chosen before any valid way.
- R7: When all four ways are valid, the victim comes from a 3-bit tree per set. Bit 0 set selects ways 2/3 and clear selects ways 0/1. Bit 1 picks way 1 over way 0 when set. Bit 2 picks way 3 over way 2 when set. Every hit and every install points the bits away from the way just used.
- R8: A modified victim is written to memory at its own tag and set address, with its data, before the fetch starts. A clean victim causes no memory write.
- R9: An installed line is valid, unmodified, and carries the request tag. The access is then replayed and hits.
- R10: A write miss allocates the line by fetching it, then merges the write data and marks the line modified. The new data is not written to memory at that time.
- R11: A memory request keeps its address, direction and write data stable until it is acknowledged.
- R12: After reset every line is invalid, the replacement trees are cleared, and both the stall and the memory request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data from the matching way |
| cpu_hit | output | 1 | Request hit in the current cycle |
| cpu_stall | output | 1 | Request must be held; the access is not complete |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write-back, 0 = line fetch |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Fetched word, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the memory request |

## Verification
Most internal faults in this block reach the ports late. A wrong tree bit or a wrong invalid-way choice shows nothing until a later miss in the same set. At that point the write-back address names the wrong tag, or a write-back appears where none should be. The bench therefore fills sets with modified lines and reads the write-back address on each eviction. A dirty flag that is not cleared on install shows the same way, as a write-back of a line that was only read. A bad compare or a bad selector shows in the same cycle, as a stall on a repeated access or as wrong read data.

// File: rtl/sa4_cache_pkg.sv
`timescale 1ns/1ps
package sa4_cache_pkg;
    localparam int NWAYS = 4;
    localparam int WAY_W = $clog2(NWAYS);

    typedef logic [WAY_W-1:0] way_t;
    typedef logic [2:0]       tree_t;

    typedef enum logic [1:0] {
        ST_LOOKUP,
        ST_EVICT,
        ST_FETCH,
        ST_INSTALL
    } state_t;

    // bit0 chooses the half, bit1 the lower pair, bit2 the upper pair
    function automatic way_t tree_pick(tree_t t);
        if (t[0]) return {1'b1, t[2]};
        return {1'b0, t[1]};
    endfunction

    // point every node on the path away from the way just used
    function automatic tree_t tree_touch(tree_t t, way_t w);
        tree_t n;
        n    = t;
        n[0] = ~w[1];
        if (w[1]) n[2] = ~w[0];
        else      n[1] = ~w[0];
        return n;
    endfunction
endpackage

// File: rtl/sa4_way_store.sv
`timescale 1ns/1ps
module sa4_way_store #(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    // status bits are reset, payload arrays are not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx]  <= wr_tag;
            data_q[idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_data  = data_q[idx];
endmodule

// File: rtl/sa4_plru.sv
`timescale 1ns/1ps
module sa4_plru
    import sa4_cache_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output way_t             pick_way,
    input  logic             touch_en,
    input  way_t             touch_way
);
    localparam int SETS = 1 << IDX_W;

    tree_t tree_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[idx] <= tree_touch(tree_q[idx], touch_way);
        end
    end

    assign pick_way = tree_pick(tree_q[idx]);
endmodule

// File: rtl/sa4_ctrl.sv
`timescale 1ns/1ps
module sa4_ctrl
    import sa4_cache_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic [TAG_W-1:0]              cpu_tag,
    input  logic [IDX_W-1:0]              cpu_idx,
    input  logic [DATA_W-1:0]             cpu_wdata,
    input  logic                          lookup_hit,
    input  way_t                          hit_way,
    input  logic [NWAYS-1:0]              valid_vec,
    input  logic [NWAYS-1:0]              dirty_vec,
    input  logic [NWAYS-1:0][TAG_W-1:0]   way_tags,
    input  logic [NWAYS-1:0][DATA_W-1:0]  way_data,
    input  way_t                          tree_way,
    input  logic                          mem_ack,
    input  logic [DATA_W-1:0]             mem_rdata,
    output logic                          cpu_stall,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [TAG_W+IDX_W+OFF_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    output logic [NWAYS-1:0]              st_we,
    output logic                          st_dirty,
    output logic [TAG_W-1:0]              st_tag,
    output logic [DATA_W-1:0]             st_data,
    output logic                          touch_en,
    output way_t                          touch_way,
    output state_t                        state_o,
    output way_t                          vic_way_o
);
    state_t            state_q, state_d;
    way_t              vic_q, pick;
    logic [DATA_W-1:0] fill_q;
    logic              miss_now;

    assign miss_now = (state_q == ST_LOOKUP) && cpu_req && !lookup_hit;

    // lowest invalid way wins, else the tree choice
    always_comb begin
        pick = tree_way;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) pick = way_t'(w);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP:  if (miss_now)
                            state_d = (valid_vec[pick] && dirty_vec[pick]) ? ST_EVICT : ST_FETCH;
            ST_EVICT:   if (mem_ack) state_d = ST_FETCH;
            ST_FETCH:   if (mem_ack) state_d = ST_INSTALL;
            ST_INSTALL: state_d = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vic_q  <= '0;
            fill_q <= '0;
        end else begin
            if (miss_now) vic_q <= pick;
            if (state_q == ST_FETCH && mem_ack) fill_q <= mem_rdata;
        end
    end

    always_comb begin
        cpu_stall = 1'b1;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {cpu_tag, cpu_idx, {OFF_W{1'b0}}};
        mem_wdata = way_data[vic_q];
        st_we     = '0;
        st_dirty  = 1'b0;
        st_tag    = cpu_tag;
        st_data   = cpu_wdata;
        touch_en  = 1'b0;
        touch_way = hit_way;
        unique case (state_q)
            ST_LOOKUP: begin
                cpu_stall = cpu_req && !lookup_hit;
                if (cpu_req && lookup_hit) begin
                    touch_en = 1'b1;
                    if (cpu_we) begin
                        st_we[hit_way] = 1'b1;
                        st_dirty       = 1'b1;
                    end
                end
            end
            ST_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {way_tags[vic_q], cpu_idx, {OFF_W{1'b0}}};
            end
            ST_FETCH: begin
                mem_req = 1'b1;
            end
            ST_INSTALL: begin
                st_we[vic_q] = 1'b1;
                st_data      = fill_q;
                touch_en     = 1'b1;
                touch_way    = vic_q;
            end
        endcase
    end

    assign state_o   = state_q;
    assign vic_way_o = vic_q;
endmodule

// File: rtl/sa4_cache.sv
`timescale 1ns/1ps
module sa4_cache
    import sa4_cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [TAG_W-1:0]                 cpu_tag;
    logic [IDX_W-1:0]                 cpu_idx;
    logic                             unused_offset;
    logic [NWAYS-1:0]                 rd_valid, rd_dirty, way_hit, st_we;
    logic [NWAYS-1:0][TAG_W-1:0]      rd_tag;
    logic [NWAYS-1:0][DATA_W-1:0]     rd_data;
    logic                             lookup_hit, st_dirty, touch_en;
    logic [TAG_W-1:0]                 st_tag;
    logic [DATA_W-1:0]                st_data;
    way_t                             hit_way, tree_way, touch_way, vic_way;
    state_t                           state;

    assign cpu_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_idx       = cpu_addr[OFF_W +: IDX_W];
    assign unused_offset = ^cpu_addr[OFF_W-1:0];

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        sa4_way_store #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W),
            .DATA_W(DATA_W)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .idx     (cpu_idx),
            .rd_valid(rd_valid[w]),
            .rd_dirty(rd_dirty[w]),
            .rd_tag  (rd_tag[w]),
            .rd_data (rd_data[w]),
            .wr_en   (st_we[w]),
            .wr_dirty(st_dirty),
            .wr_tag  (st_tag),
            .wr_data (st_data)
        );
        assign way_hit[w] = rd_valid[w] && (rd_tag[w] == cpu_tag);
    end

    assign lookup_hit = |way_hit;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (way_hit[w]) hit_way = way_t'(w);
        end
    end

    assign cpu_rdata = lookup_hit ? rd_data[hit_way] : '0;
    assign cpu_hit   = cpu_req && lookup_hit && (state == ST_LOOKUP);

    sa4_plru #(.IDX_W(IDX_W)) u_plru (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (cpu_idx),
        .pick_way (tree_way),
        .touch_en (touch_en),
        .touch_way(touch_way)
    );

    sa4_ctrl #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W),
        .OFF_W (OFF_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_tag   (cpu_tag),
        .cpu_idx   (cpu_idx),
        .cpu_wdata (cpu_wdata),
        .lookup_hit(lookup_hit),
        .hit_way   (hit_way),
        .valid_vec (rd_valid),
        .dirty_vec (rd_dirty),
        .way_tags  (rd_tag),
        .way_data  (rd_data),
        .tree_way  (tree_way),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .cpu_stall (cpu_stall),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .st_we     (st_we),
        .st_dirty  (st_dirty),
        .st_tag    (st_tag),
        .st_data   (st_data),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .state_o   (state),
        .vic_way_o (vic_way)
    );
endmodule

// File: rtl/sa4_cache_chk.sv
`timescale 1ns/1ps
module sa4_cache_chk
    import sa4_cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_hit,
    input logic              cpu_stall,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [NWAYS-1:0]  way_hit,
    input logic [NWAYS-1:0]  valid_vec,
    input logic [NWAYS-1:0]  dirty_vec,
    input state_t            state,
    input way_t              vic_way
);
    p_onehot_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> (!cpu_stall && !mem_req));

    p_miss_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_hit) |-> cpu_stall);

    p_fetch_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |->
            (mem_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W] && mem_addr[OFF_W-1:0] == '0));

    p_write_hit_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hit && cpu_we) |=> !mem_req);

    p_invalid_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP && cpu_req && !(|way_hit) && !(&valid_vec)) |=> !valid_vec[vic_way]);

    p_wb_dirty_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (valid_vec[vic_way] && dirty_vec[vic_way]));

    p_wb_then_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    p_install_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INSTALL) |=> (valid_vec[vic_way] && !dirty_vec[vic_way] && way_hit[vic_way]));

    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind sa4_cache sa4_cache_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFF_W (OFF_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .cpu_hit  (cpu_hit),
    .cpu_stall(cpu_stall),
    .cpu_addr (cpu_addr),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .way_hit  (way_hit),
    .valid_vec(rd_valid),
    .dirty_vec(rd_dirty),
    .state    (state),
    .vic_way  (vic_way)
);

// File: tb/sim_sa4_cache.sv
`timescale 1ns/1ps
module sim_sa4_cache;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_hit, cpu_stall;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int          n_checks = 0;
    int          n_err    = 0;
    int          wb_cnt   = 0;
    int          rd_cnt   = 0;
    logic [31:0] last_wb_addr, last_wb_data, last_rd_addr;
    logic [31:0] bmem [logic [31:0]];
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    sa4_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] mk(input logic [21:0] tag, input logic [7:0] idx);
        return {tag, idx, 2'b00};
    endfunction

    function automatic logic [31:0] dflt(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_1234;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: three-cycle latency, checks request stability (R11)
    initial begin : responder
        int          lat;
        logic [31:0] h_addr;
        logic        h_we;
        bit          held;
        mem_ack = 1'b0; mem_rdata = '0; lat = 0; h_addr = '0; h_we = 1'b0; held = 1'b1;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (lat == 0) begin
                    h_addr = mem_addr; h_we = mem_we; held = 1'b1;
                end else if (mem_addr !== h_addr || mem_we !== h_we) begin
                    held = 1'b0;
                end
                if (lat == 2) begin
                    chk(held, "R11", "memory request changed before ack", mem_addr, h_addr);
                    if (mem_we) begin
                        bmem[mem_addr] = mem_wdata;
                        wb_cnt++; last_wb_addr = mem_addr; last_wb_data = mem_wdata;
                    end else begin
                        mem_rdata = bmem.exists(mem_addr) ? bmem[mem_addr] : dflt(mem_addr);
                        rd_cnt++; last_rd_addr = mem_addr;
                    end
                    mem_ack = 1'b1;
                    lat = 0;
                end else begin
                    lat++;
                end
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        stalls = 0;
        #1;
        while (cpu_stall && stalls < 1000) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] rd; int st;
        #1;
        chk(!cpu_stall, "R12", "stall after reset", 32'(cpu_stall), 0);
        chk(!mem_req,   "R12", "mem_req after reset", 32'(mem_req), 0);
        chk(!cpu_hit,   "R12", "hit after reset", 32'(cpu_hit), 0);
        access(1'b0, mk(22'h2_0000, 8'h01), '0, rd, st);
        chk(st > 0, "R12", "first access must miss", 32'(st), 1);
    endtask

    task automatic t_read_paths();
        logic [31:0] a, rd; int st, r0;
        a  = mk(22'h00123, 8'h10);
        r0 = rd_cnt;
        access(1'b0, a, '0, rd, st);
        chk(st > 0,           "R4", "read miss stalls", 32'(st), 1);
        chk(rd == dflt(a),    "R4", "read miss data", rd, dflt(a));
        chk(rd_cnt == r0 + 1, "R4", "one fetch", 32'(rd_cnt - r0), 1);
        chk(last_rd_addr == a, "R1", "fetch address aligned", last_rd_addr, a);
        access(1'b0, a, '0, rd, st);
        chk(st == 0,          "R2", "repeat read hits without stall", 32'(st), 0);
        chk(rd == dflt(a),    "R2", "hit data", rd, dflt(a));
        chk(rd_cnt == r0 + 1, "R2", "no fetch on hit", 32'(rd_cnt - r0), 1);
        access(1'b0, a | 32'h3, '0, rd, st);
        chk(st == 0 && rd == dflt(a), "R1", "offset bits ignored", rd, dflt(a));
        access(1'b0, mk(22'h00122, 8'h10), '0, rd, st);
        chk(st > 0, "R1", "tag bit 10 distinguishes", 32'(st), 1);
        access(1'b0, mk(22'h00123, 8'h11), '0, rd, st);
        chk(st > 0, "R1", "index bit 2 selects another set", 32'(st), 1);
    endtask

    task automatic t_write_hit();
        logic [31:0] a, rd; int st, w0;
        a  = mk(22'h00123, 8'h10);
        w0 = wb_cnt;
        access(1'b1, a, 32'hCAFE_0001, rd, st);
        chk(st == 0,     "R5", "write hit no stall", 32'(st), 0);
        chk(wb_cnt == w0, "R5", "write hit no memory write", 32'(wb_cnt - w0), 0);
        access(1'b0, a, '0, rd, st);
        chk(rd == 32'hCAFE_0001, "R5", "write hit data read back", rd, 32'hCAFE_0001);
    endtask

    task automatic t_write_miss();
        logic [31:0] b, rd; int st, w0, r0;
        b = mk(22'h3ABCD, 8'h30); w0 = wb_cnt; r0 = rd_cnt;
        access(1'b1, b, 32'h1234_5678, rd, st);
        chk(st > 0,            "R10", "write miss stalls", 32'(st), 1);
        chk(rd_cnt == r0 + 1,  "R10", "write miss fetches line", 32'(rd_cnt - r0), 1);
        chk(wb_cnt == w0,      "R10", "no write-through", 32'(wb_cnt - w0), 0);
        access(1'b0, b, '0, rd, st);
        chk(st == 0 && rd == 32'h1234_5678, "R10", "merged data", rd, 32'h1234_5678);
    endtask

    task automatic t_clean_evict();
        logic [31:0] rd; int st, w0;
        w0 = wb_cnt;
        for (int i = 0; i < 5; i++) access(1'b0, mk(22'(22'h100 + i), 8'h50), '0, rd, st);
        chk(st > 0, "R8", "fifth tag misses", 32'(st), 1);
        access(1'b0, mk(22'h100, 8'h50), '0, rd, st);
        chk(st > 0, "R9", "evicted tag misses again", 32'(st), 1);
        chk(wb_cnt == w0, "R9", "installed clean lines never written back", 32'(wb_cnt - w0), 0);
    endtask

    task automatic t_replacement();
        logic [31:0] rd; int st, w0;
        logic [7:0] s;
        s  = 8'h77; w0 = wb_cnt;
        for (int i = 1; i <= 4; i++) access(1'b1, mk(22'(22'h200 + i), s), 32'hD000_0000 + i, rd, st);
        chk(wb_cnt == w0, "R6", "invalid ways used before any eviction", 32'(wb_cnt - w0), 0);
        access(1'b0, mk(22'h201, s), '0, rd, st);
        chk(st == 0 && rd == 32'hD000_0001, "R2", "hit on way 0", rd, 32'hD000_0001);
        access(1'b0, mk(22'h206, s), '0, rd, st);
        chk(wb_cnt == w0 + 1, "R8", "dirty victim written", 32'(wb_cnt - w0), 1);
        chk(last_wb_addr == mk(22'h203, s), "R7", "first victim is way 2", last_wb_addr, mk(22'h203, s));
        chk(last_wb_data == 32'hD000_0003, "R8", "write-back data", last_wb_data, 32'hD000_0003);
        chk(rd == dflt(mk(22'h206, s)), "R8", "fetch after write-back", rd, dflt(mk(22'h206, s)));
        access(1'b0, mk(22'h207, s), '0, rd, st);
        chk(last_wb_addr == mk(22'h202, s), "R7", "second victim is way 1", last_wb_addr, mk(22'h202, s));
        chk(last_wb_data == 32'hD000_0002, "R8", "second write-back data", last_wb_data, 32'hD000_0002);
        access(1'b0, mk(22'h208, s), '0, rd, st);
        chk(last_wb_addr == mk(22'h204, s), "R7", "third victim is way 3", last_wb_addr, mk(22'h204, s));
    endtask

    task automatic t_single_copy();
        logic [31:0] x, rd; int st, w0;
        x = mk(22'h0F00, 8'hA0); w0 = wb_cnt;
        access(1'b1, x, 32'h0000_AAAA, rd, st);
        access(1'b1, x, 32'h0000_BBBB, rd, st);
        chk(st == 0, "R3", "second write hits existing line", 32'(st), 0);
        for (int i = 1; i <= 3; i++) access(1'b0, mk(22'(22'h0F00 + i), 8'hA0), '0, rd, st);
        chk(wb_cnt == w0, "R3", "no duplicate way consumed", 32'(wb_cnt - w0), 0);
        access(1'b0, x, '0, rd, st);
        chk(st == 0 && rd == 32'h0000_BBBB, "R3", "single copy holds last write", rd, 32'h0000_BBBB);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not finish, requirements R1-R12 incomplete");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin : main
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_paths();
        t_write_hit();
        t_write_miss();
        t_clean_evict();
        t_replacement();
        t_single_copy();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule